// File: doc/BRIEF.md
# DRAM Device Cycle Decoder

This block is a synthesizable behavioural model of the control side of a four-bit-wide asynchronous DRAM. The device strobes are active low. They are sampled on a system clock, and the block classifies every access from the order in which the strobes move. The access kinds are read, early write, late write, read-modify-write, refresh of an addressed row, and refresh driven by an internal row counter. It keeps a small parameterized cell array and steers the data pins through a separate data-out bus with an enable. The row counter advances on each counter-driven refresh. A per-row bitmap records every row that has been activated since reset, so a bench can check refresh coverage.

All strobe edges are found by comparing each sample with the one before it. Every output is registered and is valid one clock after the sample that caused it. A row is opened when the row strobe falls. Each later fall of the column strobe latches a new column within that same row. The column strobe must fall at least one sample after the row strobe.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset, `dq_oe` is 0, `cyc_class` is 0 (none), `refresh_row` is 0 and `refreshed_map` is all zeros.
- R2: When `cas_n` is low in two samples in a row and `ras_n` falls in the second one, the block performs a counter-driven refresh. `cyc_class` becomes 6, the map bit for the current `refresh_row` is set, `refresh_row` increments, and `dq_oe` stays 0. Map bits are never cleared except by reset.
- R3: A fall of `ras_n` while `cas_n` is high sets `cyc_class` to 5. It sets the map bit of row `addr[ROW_W-1:0]`, leaves `refresh_row` unchanged and keeps `dq_oe` at 0 until a column cycle begins.
- R4: A fall of `cas_n` with `we_n` high starts a read (`cyc_class` 1). While `oe_n` stays low, `dq_oe` is 1 and `dq_out` carries the stored word at (open row, latched column).
- R5: A fall of `cas_n` while `we_n` is already low is an early write (`cyc_class` 2). It stores `dq_in` from that sample, and `dq_oe` stays 0 for the whole column cycle, whatever `oe_n` is.
- R6: A fall of `we_n` during a read column cycle with `oe_n` high stores `dq_in` from that sample. `cyc_class` becomes 4 if `oe_n` was low at any earlier sample of that column cycle, and 3 otherwise.
- R7: A fall of `we_n` during a read column cycle while `oe_n` is low writes nothing. `cyc_class` stays 1 and `dq_out` keeps driving the read word.
- R8: The column is `addr[COL_W-1:0]`, and higher address bits have no effect on the column selected.
- R9: With `ras_n` high, or `cas_n` high, `dq_oe` is 0 in the next cycle.
- R10: `refresh_row` has `ROW_W` bits and wraps from `2**ROW_W-1` to 0.
- R11: Within one `ras_n` low period, successive `cas_n` falls select new columns of the row latched when `ras_n` fell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DQ_W | Write data from the pins |
| dq_out | output | DQ_W | Read data toward the pins, 0 when not driving |
| dq_oe | output | 1 | Pin drive enable |
| cyc_class | output | 3 | Last classified access kind (0 none, 1 read, 2 early write, 3 late write, 4 read-modify-write, 5 addressed refresh, 6 counter refresh) |
| refresh_row | output | ROW_W | Next row for a counter-driven refresh |
| refreshed_map | output | 2**ROW_W | One bit per row, set when that row is activated |

## Verification
Every result appears exactly one clock after the sample that holds the strobe edge: the class, the counter step, the map bit, the pin enable and read data, and the write into the array. A stored word shows up on `dq_out` one clock after the column strobe falls in a later read. The bench changes inputs on falling clock edges and samples outputs on the next falling edge, so the single rising edge in between is the one that produces the result. A behavioural model in the bench advances on the same rising edges and is compared with the outputs at every falling edge. Directed checks at the same points cover the ordering corner cases.

// File: rtl/dcd_pkg.sv
// Package: shared encodings for the DRAM cycle decoder.
// Assumes: cyc_class codes are visible at the top port and must stay fixed.
package dcd_pkg;

    typedef enum logic [2:0] {
        CYC_NONE     = 3'd0,
        CYC_READ     = 3'd1,
        CYC_EWRITE   = 3'd2,
        CYC_LWRITE   = 3'd3,
        CYC_RMW      = 3'd4,
        CYC_RAS_ONLY = 3'd5,
        CYC_CBR      = 3'd6
    } cycle_kind_e;

    typedef enum logic [1:0] {
        RM_IDLE = 2'd0,
        RM_OPEN = 2'd1,
        RM_CTR  = 2'd2
    } row_mode_e;

    typedef enum logic [1:0] {
        CM_NONE   = 2'd0,
        CM_READ   = 2'd1,
        CM_EWRITE = 2'd2,
        CM_DONE   = 2'd3
    } col_mode_e;

endpackage

// File: rtl/dcd_strobe_edges.sv
// Module: dcd_strobe_edges
// Registers the previous sample of each active-low strobe and flags falls.
// Assumes: strobes are already synchronous to clk; the idle level is high.
module dcd_strobe_edges #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] fall
);

    logic [W-1:0] lvl_q;

    // Keep last sample; reset to the inactive (high) level.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '1;
        else        lvl_q <= lvl;
    end

    // One fall detector per strobe.
    generate
        for (genvar i = 0; i < W; i++) begin : g_fall
            assign fall[i] = lvl_q[i] & ~lvl[i];
        end
    endgenerate

endmodule

// File: rtl/dcd_refresh_ctr.sv
// Module: dcd_refresh_ctr
// Internal row counter for counter-driven refresh; wraps at 2**ROW_W.
// Assumes: one increment per refresh, requested as a single-cycle pulse.
module dcd_refresh_ctr #(
    parameter int ROW_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [ROW_W-1:0] count
);

    // Advance by one on request; natural wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + ROW_W'(1);
    end

endmodule

// File: rtl/dcd_cell_array.sv
// Module: dcd_cell_array
// Row x column store of DQ_W-bit words; synchronous write, combinational read.
// Assumes: contents are undefined until written (no reset on the array).
module dcd_cell_array #(
    parameter int ROW_W = 4,
    parameter int COL_W = 3,
    parameter int DQ_W  = 4
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [COL_W-1:0] wr_col,
    input  logic [DQ_W-1:0]  wr_data,
    input  logic [ROW_W-1:0] rd_row,
    input  logic [COL_W-1:0] rd_col,
    output logic [DQ_W-1:0]  rd_data
);

    localparam int ROWS = 1 << ROW_W;
    localparam int COLS = 1 << COL_W;

    logic [DQ_W-1:0] cells [ROWS][COLS];

    // Store one word per write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_row][wr_col] <= wr_data;
    end

    // Read port follows the addressed cell.
    assign rd_data = cells[rd_row][rd_col];

endmodule

// File: rtl/dram_cycle_decoder.sv
// Module: dram_cycle_decoder (top)
// Decodes sampled DRAM strobes into access kinds, keeps the cell array, the
// refresh row counter and the per-row activation map, and drives the DQ pins.
// Assumes: CAS# falls at least one sample after RAS#; all outputs registered.
module dram_cycle_decoder
    import dcd_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 3,
    parameter int DQ_W   = 4,
    parameter int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ras_n,
    input  logic                  cas_n,
    input  logic                  we_n,
    input  logic                  oe_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DQ_W-1:0]       dq_in,
    output logic [DQ_W-1:0]       dq_out,
    output logic                  dq_oe,
    output logic [2:0]            cyc_class,
    output logic [ROW_W-1:0]      refresh_row,
    output logic [(1<<ROW_W)-1:0] refreshed_map
);

    localparam int ROWS = 1 << ROW_W;

    logic [2:0] falls;
    logic       ras_fall, cas_fall, we_fall;

    row_mode_e        row_mode_q, row_mode_d;
    col_mode_e        col_mode_q, col_mode_d;
    cycle_kind_e      cls_q, cls_d;
    logic [ROW_W-1:0] row_q, row_d;
    logic [COL_W-1:0] col_q, col_d;
    logic             drove_q, drove_d;
    logic             ctr_inc, mark_en, wr_en;
    logic [ROW_W-1:0] mark_row;
    logic [DQ_W-1:0]  rd_word;
    logic             dq_oe_d;
    logic [ROWS-1:0]  map_q;

    dcd_strobe_edges #(.W(3)) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({we_n, cas_n, ras_n}),
        .fall  (falls)
    );

    assign ras_fall = falls[0];
    assign cas_fall = falls[1];
    assign we_fall  = falls[2];

    dcd_refresh_ctr #(.ROW_W(ROW_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ctr_inc),
        .count (refresh_row)
    );

    dcd_cell_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W)) u_cells (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_row  (row_q),
        .wr_col  (col_d),
        .wr_data (dq_in),
        .rd_row  (row_d),
        .rd_col  (col_d),
        .rd_data (rd_word)
    );

    // Next-state decode from strobe levels, edges and current modes.
    always_comb begin
        row_mode_d = row_mode_q;
        col_mode_d = col_mode_q;
        cls_d      = cls_q;
        row_d      = row_q;
        col_d      = col_q;
        drove_d    = drove_q;
        ctr_inc    = 1'b0;
        mark_en    = 1'b0;
        mark_row   = row_q;
        wr_en      = 1'b0;
        if (ras_n) begin
            row_mode_d = RM_IDLE;
            col_mode_d = CM_NONE;
            drove_d    = 1'b0;
        end else if (ras_fall) begin
            col_mode_d = CM_NONE;
            drove_d    = 1'b0;
            mark_en    = 1'b1;
            if (!cas_n && !cas_fall) begin
                row_mode_d = RM_CTR;
                row_d      = refresh_row;
                mark_row   = refresh_row;
                ctr_inc    = 1'b1;
                cls_d      = CYC_CBR;
            end else begin
                row_mode_d = RM_OPEN;
                row_d      = addr[ROW_W-1:0];
                mark_row   = addr[ROW_W-1:0];
                cls_d      = CYC_RAS_ONLY;
            end
        end else if (row_mode_q == RM_OPEN) begin
            if (cas_n) begin
                col_mode_d = CM_NONE;
                drove_d    = 1'b0;
            end else if (cas_fall) begin
                col_d = addr[COL_W-1:0];
                if (!we_n) begin
                    col_mode_d = CM_EWRITE;
                    wr_en      = 1'b1;
                    cls_d      = CYC_EWRITE;
                end else begin
                    col_mode_d = CM_READ;
                    drove_d    = !oe_n;
                    cls_d      = CYC_READ;
                end
            end else if (col_mode_q == CM_READ) begin
                if (we_fall && oe_n) begin
                    wr_en      = 1'b1;
                    col_mode_d = CM_DONE;
                    cls_d      = drove_q ? CYC_RMW : CYC_LWRITE;
                end else if (!oe_n) begin
                    drove_d = 1'b1;
                end
            end
        end
    end

    assign dq_oe_d = (col_mode_d == CM_READ) && !oe_n;

    // State and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_mode_q <= RM_IDLE;
            col_mode_q <= CM_NONE;
            cls_q      <= CYC_NONE;
            row_q      <= '0;
            col_q      <= '0;
            drove_q    <= 1'b0;
            dq_oe      <= 1'b0;
            dq_out     <= '0;
        end else begin
            row_mode_q <= row_mode_d;
            col_mode_q <= col_mode_d;
            cls_q      <= cls_d;
            row_q      <= row_d;
            col_q      <= col_d;
            drove_q    <= drove_d;
            dq_oe      <= dq_oe_d;
            dq_out     <= dq_oe_d ? rd_word : '0;
        end
    end

    // Sticky per-row activation map.
    always_ff @(posedge clk) begin
        if (!rst_n)       map_q <= '0;
        else if (mark_en) map_q <= map_q | (ROWS'(1) << mark_row);
    end

    assign cyc_class     = cls_q;
    assign refreshed_map = map_q;

endmodule

// File: rtl/dram_cycle_decoder_chk.sv
// Module: dram_cycle_decoder_chk
// Temporal properties on the decoder ports; attached to the top by bind.
// Assumes: bench holds strobes high while reset is asserted.
module dram_cycle_decoder_chk
    import dcd_pkg::*;
#(
    parameter int ROW_W = 4,
    parameter int ROWS  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_n,
    input logic             dq_oe,
    input logic [2:0]       cyc_class,
    input logic [ROW_W-1:0] refresh_row,
    input logic [ROWS-1:0]  refreshed_map
);

    AST_IDLE_DQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ras_n) |-> !dq_oe);                                              // R9

    AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_row != $past(refresh_row)) |->
        (refresh_row == $past(refresh_row) + ROW_W'(1)));                      // R10

    AST_CTR_ONLY_CBR: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_row != $past(refresh_row)) |-> (cyc_class == CYC_CBR));      // R2

    AST_MAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(refreshed_map) & ~refreshed_map) == '0));                      // R2

    AST_CBR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_class == CYC_CBR) |-> !dq_oe);                                    // R2

    AST_RASONLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_class == CYC_RAS_ONLY) |-> !dq_oe);                               // R3

    AST_EWRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_class == CYC_EWRITE) |-> !dq_oe);                                 // R5

endmodule

bind dram_cycle_decoder dram_cycle_decoder_chk #(
    .ROW_W (ROW_W),
    .ROWS  (ROWS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ras_n         (ras_n),
    .dq_oe         (dq_oe),
    .cyc_class     (cyc_class),
    .refresh_row   (refresh_row),
    .refreshed_map (refreshed_map)
);

// File: tb/dram_cycle_decoder_tb.sv
// Bench: behavioural reference model compared every clock, plus directed checks.
module dram_cycle_decoder_tb;

    localparam int ROW_W  = 4;
    localparam int COL_W  = 3;
    localparam int DQ_W   = 4;
    localparam int ADDR_W = 4;
    localparam int ROWS   = 1 << ROW_W;
    localparam int COLS   = 1 << COL_W;
    localparam int WDOG   = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DQ_W-1:0]   dq_in = '0;
    logic [DQ_W-1:0]   dq_out;
    logic              dq_oe;
    logic [2:0]        cyc_class;
    logic [ROW_W-1:0]  refresh_row;
    logic [ROWS-1:0]   refreshed_map;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;
    bit cmp_on   = 1'b0;
    bit done     = 1'b0;

    dram_cycle_decoder #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .cyc_class(cyc_class),
        .refresh_row(refresh_row), .refreshed_map(refreshed_map)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    // ---------------- reference model ----------------
    int m_mem [ROWS*COLS];
    bit m_ras_p, m_cas_p, m_we_p;
    int m_rowmode;   // 0 idle, 1 open, 2 counter refresh
    int m_colmode;   // 0 none, 1 read, 2 early write, 3 written
    int m_row, m_col, m_cls, m_ctr;
    bit m_drove, m_oe;
    int m_out;
    bit [ROWS-1:0] m_map;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ras_p = 1; m_cas_p = 1; m_we_p = 1;
            m_rowmode = 0; m_colmode = 0; m_row = 0; m_col = 0;
            m_cls = 0; m_ctr = 0; m_drove = 0; m_oe = 0; m_out = 0; m_map = '0;
        end else begin
            if (ras_n) begin
                m_rowmode = 0; m_colmode = 0; m_drove = 0;
            end else if (m_ras_p) begin
                m_colmode = 0; m_drove = 0;
                if (!cas_n && !m_cas_p) begin
                    m_rowmode = 2; m_map[m_ctr] = 1'b1; m_row = m_ctr;
                    m_ctr = (m_ctr + 1) % ROWS; m_cls = 6;
                end else begin
                    m_rowmode = 1; m_row = addr % ROWS; m_map[m_row] = 1'b1; m_cls = 5;
                end
            end else if (m_rowmode == 1) begin
                if (cas_n) begin
                    m_colmode = 0; m_drove = 0;
                end else if (m_cas_p) begin
                    m_col = addr % COLS;
                    if (!we_n) begin
                        m_mem[m_row*COLS + m_col] = dq_in; m_colmode = 2; m_cls = 2;
                    end else begin
                        m_colmode = 1; m_drove = !oe_n; m_cls = 1;
                    end
                end else if (m_colmode == 1) begin
                    if (m_we_p && !we_n && oe_n) begin
                        m_mem[m_row*COLS + m_col] = dq_in; m_colmode = 3;
                        m_cls = m_drove ? 4 : 3;
                    end else if (!oe_n) m_drove = 1;
                end
            end
            m_oe  = (m_colmode == 1) && !oe_n;
            m_out = m_oe ? m_mem[m_row*COLS + m_col] : 0;
            m_ras_p = ras_n; m_cas_p = cas_n; m_we_p = we_n;
        end
    end

    // Compare outputs with the model on every clock.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R9 model dq_oe", int'(dq_oe), int'(m_oe));
            if (m_oe) chk("R4 model dq_out", int'(dq_out), m_out);
            chk("R6 model cyc_class", int'(cyc_class), m_cls);
            chk("R10 model refresh_row", int'(refresh_row), m_ctr);
            chk("R2 model refreshed_map", int'(refreshed_map), int'(m_map));
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG && !done) begin
            n_errors++;
            $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WDOG);
            summary();
            $finish;
        end
    end

    task automatic drv(input bit r, input bit c, input bit w, input bit o,
                       input int a, input int d);
        @(negedge clk);
        ras_n = r; cas_n = c; we_n = w; oe_n = o;
        addr = ADDR_W'(a); dq_in = DQ_W'(d);
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R1 reset state
        chk("R1 dq_oe", int'(dq_oe), 0);
        chk("R1 cyc_class", int'(cyc_class), 0);
        chk("R1 refresh_row", int'(refresh_row), 0);
        chk("R1 refreshed_map", int'(refreshed_map), 0);
        cmp_on = 1'b1;

        // R5, R8: early write row 3, col 5 via addr 13 (bit 3 ignored)
        drv(0,1,1,1, 3, 0);
        drv(0,1,0,0, 0, 0);
        drv(0,0,0,0, 13, 'hA);
        settle();
        chk("R5 class early write", int'(cyc_class), 2);
        chk("R5 no drive with oe low", int'(dq_oe), 0);
        settle();
        chk("R5 still no drive", int'(dq_oe), 0);
        drv(0,1,0,1, 0, 0);
        drv(0,0,0,1, 2, 'h6);       // R11 second column of the same page
        drv(1,1,1,1, 0, 0);
        settle();
        chk("R9 ras high dq off", int'(dq_oe), 0);

        // R4, R11, R8: reads in one page
        drv(0,1,1,1, 3, 0);
        drv(0,0,1,0, 5, 0);
        settle();
        chk("R4 read drives", int'(dq_oe), 1);
        chk("R4 read data", int'(dq_out), 'hA);
        chk("R4 class read", int'(cyc_class), 1);
        drv(0,1,1,0, 0, 0);
        settle();
        chk("R9 cas high dq off", int'(dq_oe), 0);
        drv(0,0,1,0, 2, 0);
        settle();
        chk("R11 page column 2", int'(dq_out), 'h6);
        drv(0,1,1,0, 0, 0);
        drv(0,0,1,0, 13, 0);
        settle();
        chk("R8 upper bit ignored", int'(dq_out), 'hA);
        drv(0,0,1,1, 13, 0);
        settle();
        chk("R4 oe high stops drive", int'(dq_oe), 0);
        drv(1,1,1,1, 0, 0);

        // R6 late write row 3 col 1
        drv(0,1,1,1, 3, 0);
        drv(0,0,1,1, 1, 0);
        drv(0,0,0,1, 1, 'hC);
        settle();
        chk("R6 class late write", int'(cyc_class), 3);
        drv(1,1,1,1, 0, 0);

        // R6 read-modify-write row 3 col 1
        drv(0,1,1,1, 3, 0);
        drv(0,0,1,0, 1, 0);
        settle();
        chk("R6 late write stored", int'(dq_out), 'hC);
        drv(0,0,1,1, 1, 0);
        drv(0,0,0,1, 1, 'hD);
        settle();
        chk("R6 class rmw", int'(cyc_class), 4);
        drv(1,1,1,1, 0, 0);

        // R7 suppressed late write with oe low
        drv(0,1,1,1, 3, 0);
        drv(0,0,1,0, 1, 0);
        drv(0,0,0,0, 1, 'hE);
        settle();
        chk("R7 class stays read", int'(cyc_class), 1);
        chk("R7 still driving", int'(dq_oe), 1);
        chk("R7 read data kept", int'(dq_out), 'hD);
        drv(1,1,1,1, 0, 0);
        drv(0,1,1,1, 3, 0);
        drv(0,0,1,0, 1, 0);
        settle();
        chk("R7 nothing written", int'(dq_out), 'hD);
        drv(1,1,1,1, 0, 0);

        // R3 addressed refresh of row 9
        drv(0,1,1,0, 9, 0);
        settle();
        chk("R3 class", int'(cyc_class), 5);
        chk("R3 no drive", int'(dq_oe), 0);
        chk("R3 map bit", int'(refreshed_map[9]), 1);
        chk("R3 counter unchanged", int'(refresh_row), 0);
        drv(1,1,1,1, 0, 0);

        // R2, R10 counter-driven refresh across the wrap
        for (int i = 0; i <= ROWS; i++) begin
            drv(1,0,1,1, 0, 0);
            drv(0,0,1,0, 0, 0);
            settle();
            chk("R2 class cbr", int'(cyc_class), 6);
            chk("R2 no drive", int'(dq_oe), 0);
            chk("R10 counter step", int'(refresh_row), (i + 1) % ROWS);
            drv(1,1,1,1, 0, 0);
        end
        settle();
        chk("R2 all rows covered", int'(refreshed_map), (1 << ROWS) - 1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule